// File: doc/BRIEF.md
# Banked Process-ID Address Relocator

This block keeps a small process identifier for each of the two security states and uses it to move low virtual addresses into a per-process slice of the address space before they reach the memory management unit. Software reaches the identifier through a single-word register port. Each access carries the current security state and privilege level, and a lock input can forbid secure-side writes. An access that is not allowed is refused with an undefined-access pulse. A write that is accepted raises a flush request, so that the fetch stage restarts with the new identifier.

The address path is purely combinational. A virtual address whose top identifier-width bits are all zero lies inside the lowest window (32MB with the default parameters). For such an address those top bits are replaced by the identifier of the security state presented with the address. This is the same as adding identifier × window size. Addresses above the window are not changed. With an identifier of zero, which is the value after reset, the mapping is flat.

Top module: `pid_relocator`

## Requirements
- R1: The identifier sits in register bits [31:25]. A permitted read returns it there with bits [24:0] equal to zero. A write stores only bits [31:25] of the write data and ignores bits [24:0].
- R2: Two independent copies exist, selected by `reg_secure` (1 = secure, 0 = non-secure). An access touches only the selected copy.
- R3: After reset both copies read zero and every address passes through the address path unchanged.
- R4: A read or write with `reg_priv` = 0 asserts `undef_pulse`, returns zero read data and leaves both copies unchanged.
- R5: A privileged write with `reg_secure` = 1 while `sec_wr_lock` = 1 asserts `undef_pulse` and does not update the register. A non-secure privileged write is accepted whatever the value of `sec_wr_lock`.
- R6: A privileged secure read is always permitted, including while `sec_wr_lock` = 1, and returns the secure copy.
- R7: When `va_in[31:25]` is zero, `mva_out` equals `va_in` with bits [31:25] replaced by the copy selected by `va_secure` (1 = secure).
- R8: When `va_in[31:25]` is non-zero, `mva_out` equals `va_in`.
- R9: Every accepted write drives `flush_req` high for exactly the following clock cycle. A refused write, or a cycle with no write, produces no flush.
- R10: An accepted write is visible on the read port and the address path from the cycle after the write edge.
- R11: `undef_pulse` is high only in the cycle in which the refused strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_secure | input | 1 | Security state of the register access (1 = secure) |
| reg_priv | input | 1 | Privilege of the register access (1 = privileged) |
| sec_wr_lock | input | 1 | Forbids secure-state writes while high |
| reg_rdata | output | 32 | Read data; zero unless a permitted read is present |
| undef_pulse | output | 1 | The access in this cycle is refused |
| flush_req | output | 1 | Pipeline flush request, the cycle after an accepted write |
| va_in | input | 32 | Virtual address from the core |
| va_secure | input | 1 | Security state for the address (1 = secure) |
| mva_out | output | 32 | Relocated virtual address |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a 7-bit identifier, which gives a 25-bit window. At this width every identifier value can be reached by random writes, so the address path is exercised with both small and large identifiers in both banks. The random addresses put half of their samples inside the window and half outside it. Directed cases cover the window's last address and the first address above it. They also cover a secure write while the lock is high followed by a non-secure write, and back-to-back accepted writes that keep `flush_req` high.

// File: rtl/pid_reloc_pkg.sv
package pid_reloc_pkg;
  localparam int NUM_BANKS = 2;
  localparam logic BANK_NS = 1'b0;
  localparam logic BANK_S  = 1'b1;

  typedef struct packed {
    logic rd_ok;
    logic wr_ok;
    logic undef;
  } acc_dec_t;
endpackage

// File: rtl/pid_access_ctrl.sv
module pid_access_ctrl
  import pid_reloc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rd,
  input  logic     wr,
  input  logic     secure,
  input  logic     priv,
  input  logic     lock,
  output acc_dec_t dec
);
  logic wr_blocked;

  always_comb begin
    wr_blocked = secure & lock;
    dec.rd_ok  = rd & priv;
    dec.wr_ok  = wr & priv & ~wr_blocked;
    dec.undef  = ((rd | wr) & ~priv) | (wr & priv & wr_blocked);
  end

  // R5: a locked secure write is never accepted
  p_locked_secure_wr_r5: assert property (@(posedge clk) disable iff (rst)
    (wr && secure && lock) |-> !dec.wr_ok);
  // R11: no refusal without a strobe
  p_undef_needs_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    dec.undef |-> (rd || wr));
  // R4: refused and accepted writes are exclusive
  p_undef_excl_wr_r4: assert property (@(posedge clk) disable iff (rst)
    !(dec.undef && dec.wr_ok));
endmodule

// File: rtl/pid_bank_file.sv
module pid_bank_file
  import pid_reloc_pkg::*;
#(
  parameter int ID_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [ID_W-1:0] wr_id,
  input  logic            rd_sel,
  output logic [ID_W-1:0] rd_id,
  input  logic            va_sel,
  output logic [ID_W-1:0] va_id,
  output logic            flush_q
);
  logic [ID_W-1:0] id_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) id_q[b] <= '0;
      else if (wr_en && (wr_sel == b[0])) id_q[b] <= wr_id;
    end

    // R4/R5: a copy changes only through an accepted write aimed at it
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && (wr_sel == b[0])) |=> $stable(id_q[b]));
  end

  always_ff @(posedge clk) begin
    if (rst) flush_q <= 1'b0;
    else     flush_q <= wr_en;
  end

  assign rd_id = id_q[rd_sel];
  assign va_id = id_q[va_sel];

  // R9: flush follows an accepted write by one cycle
  p_flush_after_wr_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> flush_q);
endmodule

// File: rtl/pid_va_remap.sv
module pid_va_remap #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 7
) (
  input  logic [ADDR_W-1:0] va,
  input  logic [ID_W-1:0]   id,
  output logic [ADDR_W-1:0] mva
);
  localparam int LSB = ADDR_W - ID_W;

  logic in_window;

  always_comb begin
    in_window = (va[ADDR_W-1:LSB] == '0);
    mva       = in_window ? {id, va[LSB-1:0]} : va;
  end

  // R7/R8: the offset inside the window never changes
  always_comb begin
    p_low_bits_kept_r7: assert (mva[LSB-1:0] == va[LSB-1:0]);
  end
endmodule

// File: rtl/pid_relocator.sv
module pid_relocator
  import pid_reloc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              reg_secure,
  input  logic              reg_priv,
  input  logic              sec_wr_lock,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              undef_pulse,
  output logic              flush_req,
  input  logic [ADDR_W-1:0] va_in,
  input  logic              va_secure,
  output logic [ADDR_W-1:0] mva_out
);
  localparam int LSB = ADDR_W - ID_W;

  acc_dec_t        dec;
  logic [ID_W-1:0] rd_id;
  logic [ID_W-1:0] va_id;
  logic            unused_wlow;

  assign unused_wlow = ^reg_wdata[LSB-1:0];

  pid_access_ctrl u_acc (
    .clk(clk), .rst(rst), .rd(reg_rd), .wr(reg_wr), .secure(reg_secure),
    .priv(reg_priv), .lock(sec_wr_lock), .dec(dec)
  );

  pid_bank_file #(.ID_W(ID_W)) u_banks (
    .clk(clk), .rst(rst), .wr_en(dec.wr_ok), .wr_sel(reg_secure),
    .wr_id(reg_wdata[ADDR_W-1:LSB]), .rd_sel(reg_secure), .rd_id(rd_id),
    .va_sel(va_secure), .va_id(va_id), .flush_q(flush_req)
  );

  pid_va_remap #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_remap (
    .va(va_in), .id(va_id), .mva(mva_out)
  );

  assign reg_rdata   = dec.rd_ok ? {rd_id, {LSB{1'b0}}} : '0;
  assign undef_pulse = dec.undef;

  // R9: a refused access never leads to a flush
  p_no_flush_after_undef_r9: assert property (@(posedge clk) disable iff (rst)
    (undef_pulse && !reg_rd) |=> !flush_req);
  // R8: addresses above the window are untouched
  p_high_passthru_r8: assert property (@(posedge clk) disable iff (rst)
    (va_in[ADDR_W-1:LSB] != '0) |-> (mva_out == va_in));
  // R1: reserved read bits are zero
  p_rd_low_zero_r1: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[LSB-1:0] == '0);
endmodule

// File: tb/pid_relocator_tb.sv
module pid_relocator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int IW = 7;
  localparam int LSB = AW - IW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_rd = 0, reg_wr = 0, reg_secure = 0, reg_priv = 0, sec_wr_lock = 0, va_secure = 0;
  logic [AW-1:0] reg_wdata = '0, va_in = '0;
  logic [AW-1:0] reg_rdata, mva_out;
  logic undef_pulse, flush_req;

  int n_vec = 0, n_bad = 0;
  logic [IW-1:0] mdl [2];
  logic exp_flush = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pid_relocator u_dut (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_secure(reg_secure), .reg_priv(reg_priv), .sec_wr_lock(sec_wr_lock),
    .reg_rdata(reg_rdata), .undef_pulse(undef_pulse), .flush_req(flush_req),
    .va_in(va_in), .va_secure(va_secure), .mva_out(mva_out)
  );

  function automatic logic [AW-1:0] f_mva(input logic [AW-1:0] va, input logic [IW-1:0] id);
    if (va[AW-1:LSB] == '0) return {id, va[LSB-1:0]};
    return va;
  endfunction

  function automatic logic f_wr_ok(input logic wr, pr, sec, lk);
    return wr && pr && !(sec && lk);
  endfunction

  function automatic logic f_undef(input logic rd, wr, pr, sec, lk);
    return ((rd || wr) && !pr) || (wr && pr && sec && lk);
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] act, exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check mid-low, commit at posedge
  task automatic step(input logic rd, wr, sec, pr, lk, input logic [AW-1:0] wd,
                      input logic [AW-1:0] va, input logic vs, input string tag);
    logic [AW-1:0] exp_rd;
    @(negedge clk);
    reg_rd = rd; reg_wr = wr; reg_secure = sec; reg_priv = pr; sec_wr_lock = lk;
    reg_wdata = wd; va_in = va; va_secure = vs;
    #(CLK_PERIOD/4);
    exp_rd = (rd && pr) ? {mdl[sec], {LSB{1'b0}}} : '0;
    chk({tag, " R1/R2/R4/R6 rdata"}, reg_rdata, exp_rd);
    chk({tag, " R11/R4/R5 undef"}, {31'd0, undef_pulse}, {31'd0, f_undef(rd, wr, pr, sec, lk)});
    chk({tag, " R7/R8/R10 mva"}, mva_out, f_mva(va, mdl[vs]));
    chk({tag, " R9 flush"}, {31'd0, flush_req}, {31'd0, exp_flush});
    exp_flush = f_wr_ok(wr, pr, sec, lk);
    if (exp_flush) mdl[sec] = wd[AW-1:LSB];
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] va, wd;
    void'($urandom(32'h5eed_1234));
    mdl[0] = '0; mdl[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R3: reset state, flat mapping
    step(1, 0, 1, 1, 0, '0, 32'h01ff_fff0, 1, "R3 reset-s");
    step(1, 0, 0, 1, 0, '0, 32'h0000_1234, 0, "R3 reset-ns");
    // R1/R2: write secure copy, reserved bits ignored
    step(0, 1, 1, 1, 0, 32'hA5FF_FFFF, 32'h0000_0010, 1, "R1 wr-s");
    step(1, 0, 1, 1, 0, '0, 32'h0000_0010, 1, "R10 after wr-s");
    step(1, 0, 0, 1, 0, '0, 32'h0000_0010, 0, "R2 ns untouched");
    // R5: locked secure write refused, then ns write accepted under lock
    step(0, 1, 1, 1, 1, 32'hFE00_0000, 32'h01FF_FFFF, 1, "R5 locked-s");
    step(0, 1, 0, 1, 1, 32'h0600_0000, 32'h0200_0000, 1, "R5 ns-under-lock");
    // R6: secure read under lock
    step(1, 0, 1, 1, 1, '0, 32'h01FF_FFFF, 0, "R6 rd-s-lock");
    // R4: user accesses
    step(1, 1, 1, 0, 0, 32'hFE00_0000, 32'h0200_0000, 0, "R4 user-s");
    step(0, 1, 0, 0, 0, 32'hFE00_0000, '0, 0, "R4 user-ns");
    // R9: back-to-back accepted writes
    step(0, 1, 0, 1, 0, 32'h1200_0000, '0, 0, "R9 b2b-1");
    step(0, 1, 0, 1, 0, 32'h1400_0000, '0, 0, "R9 b2b-2");
    step(0, 0, 0, 1, 0, '0, '0, 0, "R9 idle");
    step(0, 0, 0, 1, 0, '0, 32'hFFFF_FFFF, 1, "R8 top");
    for (int i = 0; i < 4000; i++) begin
      va = $urandom;
      if ($urandom_range(0, 1) == 0) va[AW-1:LSB] = '0;
      wd = $urandom;
      step($urandom_range(0, 1), $urandom_range(0, 2) == 0, $urandom_range(0, 1),
           $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, wd, va,
           $urandom_range(0, 1), "rand");
    end
    @(negedge clk);
    reg_rd = 0; reg_wr = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule